// File: doc/BRIEF.md
# Prescaled Capture Timer

This block keeps a free-running 16-bit up counter and timestamps events on eight input pins against it. A 3-bit code picks a power-of-two divide of the system clock that sets the counter's step rate. A run bit starts and stops the count. Each channel watches its pin for a chosen edge type. On a matching edge it copies the counter into its own capture register and raises its own flag. Software measures periods, pulse widths and phase offsets by subtracting captured values.

Software uses a plain register port with a write strobe, a read strobe, an address and data. Through it, software sets the counter's rate, arms channels, reads timestamps, clears flags and enables interrupts. One interrupt line combines the enabled channel flags and the counter wrap flag.

Top module: `ecap_timer`

## Requirements
- R1: With run set, the counter advances by exactly one every 2^code clock cycles, where code is the 3-bit prescale field (000 gives every cycle, 111 gives every 128 cycles).
- R2: The counter is 0 after reset and holds its value while run is 0. It counts up while run is 1, and after 0xFFFF it wraps to 0x0000 and keeps counting.
- R3: Each wrap from 0xFFFF to 0x0000 sets the wrap flag. Writing a 1 to bit 0 of address 4 clears it. The interrupt output is high while the wrap flag and the wrap interrupt enable are both 1.
- R4: Each channel has a 2-bit edge code: 00 captures nothing, 01 captures rising edges only, 10 captures falling edges only, 11 captures both.
- R5: On a selected edge, the channel's capture register receives the counter value as it stands two clock cycles after the pin change, and the channel flag is set.
- R6: A later selected edge overwrites the capture register whether or not it has been read.
- R7: Writing to the flag register (address 3, bit i = channel i) clears each flag whose data bit is 1 and leaves flags whose bit is 0 unchanged.
- R8: When fast clear (control bit 1) is 1, a strobed read of channel i's capture register clears flag i. When fast clear is 0, reads do not change the flags.
- R9: The interrupt output is high while any channel flag is set with its enable bit (address 2, bit i) set, and low when no enabled flag or wrap term is active.
- R10: If a selected edge and a clear of the same flag occur in the same cycle, the flag ends set.
- R11: Register map: address 0 is control (bit 0 run, bit 1 fast clear, bit 2 wrap interrupt enable, bits 6:4 prescale code). Address 1 holds the edge codes (channel i in bits 2i+1:2i). Address 2 holds the channel interrupt enables. Address 3 holds the channel flags. Address 4 bit 0 is the wrap flag. Address 5 reads the counter. Addresses 8 to 15 read the capture registers of channels 0 to 7. Written registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives fast clear) |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| cap_in | input | 8 | Channel input pins, bit i = channel i |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the cycle in which a flag is cleared while a new edge lands on it. A design where the clear wins would lose that event and show the flag low. For the capture value, the bench predicts the exact count from the counter read just before the pin changes. An extra or missing synchronizer stage therefore shows up as an off-by-one timestamp. The bench also checks each edge code with the opposite edge, covers fast clear both enabled and disabled, checks that zero bits in a flag write leave flags alone, and runs the counter through a full wrap. That wrap run catches a missing flag, a wrong wrap value and a wrong interrupt gating.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_EDGE  = 1;
  localparam int ADR_IEN   = 2;
  localparam int ADR_FLAG  = 3;
  localparam int ADR_WRAP  = 4;
  localparam int ADR_COUNT = 5;
  localparam int ADR_CAP0  = 8;
endpackage

// File: rtl/ecap_timebase.sv
module ecap_timebase #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_code,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] pre_q, pre_nxt, mask;
  logic [CNT_W-1:0] count_q, count_nxt;
  logic             tick;

  always_comb begin
    mask      = ~({DIV_W{1'b1}} << pre_code);
    tick      = run && ((pre_q & mask) == mask);
    pre_nxt   = run ? pre_q + 1'b1 : '0;
    count_nxt = tick ? count_q + 1'b1 : count_q;
    wrap      = tick && (count_q == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      count_q <= '0;
    end else begin
      pre_q   <= pre_nxt;
      count_q <= count_nxt;
    end
  end

  assign count = count_q;

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count_q));
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count_q == '0));
  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count_q == CNT_W'($past(count_q) + 1'b1)));
endmodule

// File: rtl/ecap_channel.sv
module ecap_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] count,
  input  logic             clr,
  output logic             flag,
  output logic [CNT_W-1:0] cap_val
);
  import ecap_pkg::*;

  logic             s0_q, s1_q, prev_q;
  logic             rise, fall, evt;
  logic             flag_q, flag_nxt;
  logic [CNT_W-1:0] cap_q, cap_nxt;

  always_comb begin
    rise = s1_q & ~prev_q;
    fall = ~s1_q & prev_q;
    unique case (edge_mode_e'(mode))
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
    // a new event outranks a same-cycle clear
    flag_nxt = evt ? 1'b1 : (clr ? 1'b0 : flag_q);
    cap_nxt  = evt ? count : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q   <= 1'b0;
      s1_q   <= 1'b0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      s0_q   <= pin;
      s1_q   <= s0_q;
      prev_q <= s1_q;
      flag_q <= flag_nxt;
      cap_q  <= cap_nxt;
    end
  end

  assign flag    = flag_q;
  assign cap_val = cap_q;

  assert_capture_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (flag_q && cap_q == $past(count)));
  assert_off_never_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !flag_q) |=> !flag_q);
  assert_clear_without_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag_q);
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt) |=> flag_q);
endmodule

// File: rtl/ecap_timer.sv
module ecap_timer #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 8,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic [NUM_CH-1:0] cap_in,
  output logic              irq
);
  import ecap_pkg::*;

  localparam int EDGE_W = 2 * NUM_CH;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_i_n = rst_sync_q;

  logic              run_q, run_nxt, ffc_q, ffc_nxt, wie_q, wie_nxt;
  logic [PRE_W-1:0]  pre_q, pre_nxt;
  logic [EDGE_W-1:0] edge_q, edge_nxt;
  logic [NUM_CH-1:0] ien_q, ien_nxt;
  logic              wrapf_q, wrapf_nxt;
  logic [CNT_W-1:0]  count;
  logic              wrap;
  logic [NUM_CH-1:0] flags, clr_vec;
  logic [CNT_W-1:0]  cap_val [NUM_CH];
  logic              wr_ctrl, wr_edge, wr_ien, wr_flag, wr_wrap;

  ecap_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) tb_i (
    .clk(clk), .rst_n(rst_i_n), .run(run_q), .pre_code(pre_q),
    .count(count), .wrap(wrap));

  always_comb begin
    wr_ctrl = wr_en && (addr == ADDR_W'(ADR_CTRL));
    wr_edge = wr_en && (addr == ADDR_W'(ADR_EDGE));
    wr_ien  = wr_en && (addr == ADDR_W'(ADR_IEN));
    wr_flag = wr_en && (addr == ADDR_W'(ADR_FLAG));
    wr_wrap = wr_en && (addr == ADDR_W'(ADR_WRAP));

    run_nxt   = wr_ctrl ? wdata[0] : run_q;
    ffc_nxt   = wr_ctrl ? wdata[1] : ffc_q;
    wie_nxt   = wr_ctrl ? wdata[2] : wie_q;
    pre_nxt   = wr_ctrl ? wdata[4 +: PRE_W] : pre_q;
    edge_nxt  = wr_edge ? wdata[EDGE_W-1:0] : edge_q;
    ien_nxt   = wr_ien  ? wdata[NUM_CH-1:0] : ien_q;
    wrapf_nxt = wrap ? 1'b1 : ((wr_wrap && wdata[0]) ? 1'b0 : wrapf_q);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      run_q   <= 1'b0;
      ffc_q   <= 1'b0;
      wie_q   <= 1'b0;
      pre_q   <= '0;
      edge_q  <= '0;
      ien_q   <= '0;
      wrapf_q <= 1'b0;
    end else begin
      run_q   <= run_nxt;
      ffc_q   <= ffc_nxt;
      wie_q   <= wie_nxt;
      pre_q   <= pre_nxt;
      edge_q  <= edge_nxt;
      ien_q   <= ien_nxt;
      wrapf_q <= wrapf_nxt;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign clr_vec[i] = (wr_flag && wdata[i]) ||
                        (rd_en && ffc_q && addr == ADDR_W'(ADR_CAP0 + i));
    ecap_channel #(.CNT_W(CNT_W)) ch_i (
      .clk(clk), .rst_n(rst_i_n), .pin(cap_in[i]),
      .mode(edge_q[2*i +: 2]), .count(count), .clr(clr_vec[i]),
      .flag(flags[i]), .cap_val(cap_val[i]));
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_CTRL))
      rdata = CNT_W'({pre_q, 1'b0, wie_q, ffc_q, run_q});
    else if (addr == ADDR_W'(ADR_EDGE))  rdata = CNT_W'(edge_q);
    else if (addr == ADDR_W'(ADR_IEN))   rdata = CNT_W'(ien_q);
    else if (addr == ADDR_W'(ADR_FLAG))  rdata = CNT_W'(flags);
    else if (addr == ADDR_W'(ADR_WRAP))  rdata = CNT_W'(wrapf_q);
    else if (addr == ADDR_W'(ADR_COUNT)) rdata = count;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(ADR_CAP0 + i)) rdata = cap_val[i];
  end

  assign irq = (|(flags & ien_q)) | (wrapf_q & wie_q);

  assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    wrap |=> wrapf_q);
  assert_wrap_irq_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wrapf_q && wie_q) |-> irq);
endmodule

// File: tb/ecap_timer_tb.sv
`timescale 1ns/100ps
module ecap_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [4:0]  addr;
  logic [15:0] wdata, rdata;
  logic [7:0]  cap_in;
  logic        irq;
  int total = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecap_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic peek(input int a, output logic [15:0] v);
    addr = 5'(a);
    #0.1;
    v = rdata;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_strobe(input int a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = 5'(a);
    #0.1;
    v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_pin(input int ch, input logic val);
    @(negedge clk);
    cap_in[ch] = val;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; cap_in = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    peek(5, v); check("R2 reset count", v, 0);
    peek(3, v); check("R7 reset flags", v, 0);
    check("R9 reset irq", irq, 0);
    repeat (20) @(negedge clk);
    peek(5, v); check("R2 hold while stopped", v, 0);
  endtask

  task automatic t_prescale;
    logic [15:0] a, b;
    int codes [3] = '{0, 3, 7};
    foreach (codes[k]) begin
      wr(0, 16'((codes[k] << 4) | 1));
      peek(5, a);
      repeat (256) @(negedge clk);
      peek(5, b);
      check($sformatf("R1 prescale code %0d", codes[k]), 16'(b - a), 16'(256 >> codes[k]));
    end
    wr(0, 16'h0000);
    peek(5, a);
    repeat (10) @(negedge clk);
    peek(5, b);
    check("R2 stop holds count", b, a);
  endtask

  task automatic t_capture;
    logic [15:0] c, v;
    wr(1, 16'h01C9);
    peek(1, v); check("R11 edge code readback", v, 16'h01C9);
    wr(0, 16'h0001);
    @(negedge clk);
    peek(5, c);
    cap_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    peek(3, v); check("R5 flag set", v, 16'h0001);
    peek(8, v); check("R5 capture value", v, 16'(c + 2));
    c = v;
    set_pin(0, 1'b0);
    peek(8, v); check("R4 rise-only ignores fall", v, c);
    @(negedge clk);
    peek(5, c);
    cap_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    peek(8, v); check("R6 overwrite unread", v, 16'(c + 2));
    set_pin(0, 1'b0);
    wr(3, 16'h00FE);
    peek(3, v); check("R7 zero bits keep flag", v, 16'h0001);
    wr(3, 16'h0001);
    peek(3, v); check("R7 one bit clears flag", v, 16'h0000);
  endtask

  task automatic t_modes;
    logic [15:0] v;
    set_pin(1, 1'b1);
    peek(3, v); check("R4 fall-only ignores rise", v[1], 0);
    set_pin(1, 1'b0);
    peek(3, v); check("R4 fall-only captures fall", v[1], 1);
    set_pin(2, 1'b1);
    set_pin(2, 1'b0);
    peek(3, v); check("R4 code 00 no flag", v[2], 0);
    peek(10, v); check("R4 code 00 no capture", v, 0);
    set_pin(3, 1'b1);
    peek(3, v); check("R4 both-edge rise", v[3], 1);
    wr(3, 16'h0008);
    set_pin(3, 1'b0);
    peek(3, v); check("R4 both-edge fall", v[3], 1);
  endtask

  task automatic t_irq_fast;
    logic [15:0] v;
    wr(2, 16'h0000);
    check("R9 flags without enable", irq, 0);
    wr(2, 16'h0008);
    check("R9 enabled flag raises irq", irq, 1);
    wr(3, 16'h0008);
    check("R9 cleared flag drops irq", irq, 0);
    rd_strobe(9, v);
    peek(3, v); check("R8 read without fast clear", v[1], 1);
    wr(0, 16'h0003);
    rd_strobe(9, v);
    peek(3, v); check("R8 read with fast clear", v[1], 0);
    wr(0, 16'h0001);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    set_pin(4, 1'b1);
    set_pin(4, 1'b0);
    peek(3, v); check("R10 setup flag", v[4], 1);
    @(negedge clk);
    cap_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'd3; wdata = 16'h0010;
    @(negedge clk);
    wr_en = 1'b0;
    peek(3, v); check("R10 edge beats clear", v[4], 1);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    int n = 0;
    wr(3, 16'h00FF);
    wr(2, 16'h0000);
    wr(0, 16'h0005);
    peek(4, v);
    while (v[0] == 1'b0 && n < 70000) begin
      @(negedge clk);
      peek(4, v);
      n++;
    end
    check("R3 wrap flag set", v[0], 1);
    peek(5, v); check("R2 wrap to zero", v, 0);
    check("R3 wrap irq", irq, 1);
    wr(4, 16'h0001);
    peek(4, v); check("R3 wrap flag cleared", v[0], 0);
    check("R3 irq drops", irq, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prescale();
    t_capture();
    t_modes();
    t_irq_fast();
    t_priority();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule